// File: doc/BRIEF.md
# Serial SRAM Command Front End

This block is the slave side of a four-wire serial memory port that gives access to a 64K x 8 on-chip array. It works in SPI mode 0 or mode 3. It runs on a fast system clock and watches the serial clock, chip select and data-in lines as already-synchronised inputs. Every transfer starts with an 8-bit command. A read or write command then takes a 16-bit address, and data follows from bit time 24. All fields travel most significant bit first. The block drives a separate output enable beside its serial data output, so the pad stays undriven except while it is sending read data or register contents.

An internal status byte holds two settings. The first is a burst-mode field that decides how the address advances between data bytes: single byte, wrap inside a 32-byte page, linear from the page start, or linear with a return to the start address after the top of the array. The second is a hold-disable bit. A pause request from the neighbouring hold logic freezes the transfer while hold is enabled. A fixed size byte reports the array density. The array itself sits outside the block, behind a port with one-cycle read latency.

The control state machine has eight states. IDLE is entered from any state when chip select goes high, and moves to CMD once chip select is low. CMD collects the command byte. On the eighth bit it goes to ADDR for a read or write, to REGOUT for a status or size read, to SETSTAT for a status write, and to DISCARD for any other code. ADDR goes to RDATA or WDATA after the sixteenth address bit. SETSTAT goes to DISCARD after its data byte. RDATA, WDATA, REGOUT and DISCARD stay where they are until chip select goes high.

Top module: `spi_sram_front`

## Requirements
- R1: Command codes are 0x03 read, 0x02 write, 0x05 status read, 0x01 status write and 0x0E size read. Any other code is ignored until chip select goes high: the output enable stays low and no array write occurs.
- R2: After 0x03 and a 16-bit address, bit 7 of the addressed byte is presented after the falling serial-clock edge that follows the 24th rising edge. Each later bit follows the next falling edge. Data-in is sampled on rising edges, and both clock idle levels (mode 0 and mode 3) work.
- R3: After 0x02 and a 16-bit address, the byte clocked in on SI is written to the addressed location. The array port never asks for a read and a write in the same cycle.
- R4: Burst mode 00 (the reset default): only the first data byte of a transfer is used. Later read bytes leave the output enable low, and later write bytes change nothing.
- R5: Burst mode 01: after each byte, address bits 4:0 increment and wrap from 31 to 0, and bits 15:5 stay fixed.
- R6: Burst mode 10: the first access goes to the page start (address bits 4:0 cleared). The address then increments linearly and wraps from 0xFFFF to 0x0000.
- R7: Burst mode 11: the access starts at the given address and increments. After 0xFFFF the next access is the start address again.
- R8: A status write (0x01) stores bits 7:6 as the burst mode and bit 0 as the hold disable. Bits 5:1 read as zero. Bytes clocked after that data byte are discarded. The status resets to 0x00.
- R9: A status read (0x05) returns the status byte, repeated for every further byte clocked.
- R10: A size read (0x0E) returns 0x03 (low two bits 00/01/10/11 mean 64/128/256/512 Kbit, upper bits zero), repeated for every byte.
- R11: The output enable is low whenever chip select is high and during the command and address phases. Raising chip select ends the transfer, and the next transfer decodes a fresh command.
- R12: While `hold_pause` is high and status bit 0 is 0, the output enable is low and serial-clock edges are ignored. After release the transfer resumes at the same bit. With status bit 0 set, `hold_pause` has no effect.

SCK high and low phases must each last at least four system clocks, and chip select must be low for two system clocks before the first SCK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock, synchronised |
| cs_n | input | 1 | Active-low chip select, synchronised |
| si | input | 1 | Serial data in, synchronised |
| hold_pause | input | 1 | Pause request from the hold logic |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for the serial data pad |
| mem_addr | output | 16 | Array address |
| mem_re | output | 1 | Array read request, data returned next cycle |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data |

## Verification
Assertions check on every cycle that:
- chip select high returns the machine to IDLE with the output undriven;
- the data-out value moves only after a qualified falling edge;
- a pause freezes the bit count;
- the array port never reads and writes together;
- a page burst never leaves its page;
- a linear burst starts on a page boundary;
- a wrapping burst returns to its start.

Only the bench's transfers can show the rest:
- the byte values that appear on the serial line;
- the command decode;
- the status and size contents;
- the loss of extra single-mode bytes;
- the resumption of a transfer after a pause.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_REGOUT,
        ST_SETSTAT,
        ST_DISCARD
    } fe_state_t;

    typedef enum logic [1:0] {
        BM_SINGLE = 2'b00,
        BM_PAGE   = 2'b01,
        BM_LINEAR = 2'b10,
        BM_WINDOW = 2'b11
    } burst_mode_t;

    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_WRITE = 8'h02;
    localparam logic [7:0] CMD_RDST  = 8'h05;
    localparam logic [7:0] CMD_WRST  = 8'h01;
    localparam logic [7:0] CMD_RDSZ  = 8'h0E;

endpackage

// File: rtl/sram_fe_sck_edge.sv
module sram_fe_sck_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic hold_pause,
    input  logic hold_off,
    output logic rise,
    output logic fall,
    output logic paused
);
    logic sck_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck;
    end

    always_comb begin
        paused = hold_pause & ~hold_off & ~cs_n;
        rise   = sck & ~sck_q & ~cs_n & ~paused;
        fall   = ~sck & sck_q & ~cs_n & ~paused;
    end
endmodule

// File: rtl/sram_fe_addr_seq.sv
module sram_fe_addr_seq
    import spi_sram_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  burst_mode_t       mode,
    input  logic              load,
    input  logic [ADDR_W-1:0] start,
    input  logic              step,
    output logic [ADDR_W-1:0] cur
);
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] nxt;

    always_comb begin
        unique case (mode)
            BM_SINGLE: nxt = cur;
            BM_PAGE:   nxt = {cur[ADDR_W-1:PAGE_W], cur[PAGE_W-1:0] + 1'b1};
            BM_LINEAR: nxt = cur + 1'b1;
            BM_WINDOW: nxt = (&cur) ? base_q : cur + 1'b1;
            default:   nxt = cur;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur    <= '0;
            base_q <= '0;
        end else if (load) begin
            cur    <= (mode == BM_LINEAR) ? {start[ADDR_W-1:PAGE_W], {PAGE_W{1'b0}}} : start;
            base_q <= start;
        end else if (step) begin
            cur <= nxt;
        end
    end

    p_page_stay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && mode == BM_PAGE) |=> cur[ADDR_W-1:PAGE_W] == $past(cur[ADDR_W-1:PAGE_W]));

    p_linear_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && mode == BM_LINEAR) |=> cur[PAGE_W-1:0] == '0);

    p_window_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && mode == BM_WINDOW && (&cur)) |=> cur == $past(base_q));
endmodule

// File: rtl/sram_fe_regs.sv
module sram_fe_regs
    import spi_sram_pkg::*;
#(
    parameter logic [1:0] SIZE_CODE = 2'b11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_mode,
    input  logic        wr_hold_off,
    output burst_mode_t mode,
    output logic        hold_off,
    output logic [7:0]  status,
    output logic [7:0]  size_reg
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= BM_SINGLE;
            hold_off <= 1'b0;
        end else if (wr_en) begin
            mode     <= burst_mode_t'(wr_mode);
            hold_off <= wr_hold_off;
        end
    end

    assign status   = {mode, 5'b00000, hold_off};
    assign size_reg = {6'b000000, SIZE_CODE};

    p_stat_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(status));
endmodule

// File: rtl/spi_sram_front.sv
module spi_sram_front
    import spi_sram_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         PAGE_W    = 5,
    parameter logic [1:0] SIZE_CODE = 2'b11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              hold_pause,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    localparam int BYTE_W = 8;
    localparam int BCNT_W = $clog2(BYTE_W);
    localparam int ACNT_W = $clog2(ADDR_W);

    logic rise, fall, paused, hold_off;
    burst_mode_t mode;
    logic [7:0] status, size_reg;

    fe_state_t state, state_nx;
    logic [BCNT_W-1:0] bit_cnt;
    logic [ACNT_W-1:0] adr_cnt;
    logic [BYTE_W-2:0] shin;
    logic [ADDR_W-2:0] adr_sh;
    logic [7:0] rd_buf, tx_sh, wbyte_q;
    logic so_q, oe_q, fetch_pend, cap_pend, wr_pend, first_done, is_read, reg_is_size;

    logic [7:0] in_byte;
    logic [ADDR_W-1:0] seq_start;
    logic byte_end, adr_end, seq_load, seq_step, stat_we;

    assign in_byte   = {shin, si};
    assign seq_start = {adr_sh, si};
    assign byte_end  = rise && (bit_cnt == '1);
    assign adr_end   = rise && (adr_cnt == ACNT_W'(ADDR_W - 1));
    assign seq_load  = adr_end && (state == ST_ADDR);
    assign seq_step  = fetch_pend | wr_pend;
    assign stat_we   = byte_end && (state == ST_SETSTAT);

    sram_fe_sck_edge i_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck        (sck),
        .cs_n       (cs_n),
        .hold_pause (hold_pause),
        .hold_off   (hold_off),
        .rise       (rise),
        .fall       (fall),
        .paused     (paused)
    );

    sram_fe_regs #(.SIZE_CODE(SIZE_CODE)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (stat_we),
        .wr_mode     (in_byte[7:6]),
        .wr_hold_off (in_byte[0]),
        .mode        (mode),
        .hold_off    (hold_off),
        .status      (status),
        .size_reg    (size_reg)
    );

    sram_fe_addr_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .load  (seq_load),
        .start (seq_start),
        .step  (seq_step),
        .cur   (mem_addr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (cs_n) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_CMD;
                ST_CMD: begin
                    if (byte_end) begin
                        case (in_byte)
                            CMD_READ, CMD_WRITE: state_nx = ST_ADDR;
                            CMD_RDST, CMD_RDSZ:  state_nx = ST_REGOUT;
                            CMD_WRST:            state_nx = ST_SETSTAT;
                            default:             state_nx = ST_DISCARD;
                        endcase
                    end
                end
                ST_ADDR:    if (adr_end)  state_nx = is_read ? ST_RDATA : ST_WDATA;
                ST_SETSTAT: if (byte_end) state_nx = ST_DISCARD;
                default:    state_nx = state;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0; adr_cnt <= '0; shin <= '0; adr_sh <= '0;
            rd_buf <= '0; tx_sh <= '0; wbyte_q <= '0;
            so_q <= 1'b0; oe_q <= 1'b0; fetch_pend <= 1'b0; cap_pend <= 1'b0;
            wr_pend <= 1'b0; first_done <= 1'b0; is_read <= 1'b0; reg_is_size <= 1'b0;
        end else begin
            fetch_pend <= 1'b0;
            wr_pend    <= 1'b0;
            cap_pend   <= fetch_pend;
            if (cap_pend) rd_buf <= mem_rdata;
            if (cs_n) begin
                bit_cnt    <= '0;
                adr_cnt    <= '0;
                oe_q       <= 1'b0;
                first_done <= 1'b0;
            end else begin
                if (rise) begin
                    shin <= in_byte[BYTE_W-2:0];
                    unique case (state)
                        ST_IDLE: ;
                        ST_CMD: begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (byte_end) begin
                                is_read     <= (in_byte == CMD_READ);
                                reg_is_size <= (in_byte == CMD_RDSZ);
                                rd_buf      <= (in_byte == CMD_RDSZ) ? size_reg : status;
                            end
                        end
                        ST_ADDR: begin
                            adr_sh  <= seq_start[ADDR_W-2:0];
                            adr_cnt <= adr_cnt + 1'b1;
                            if (adr_end) fetch_pend <= is_read;
                        end
                        ST_RDATA: begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (byte_end) begin
                                first_done <= 1'b1;
                                if (mode != BM_SINGLE) fetch_pend <= 1'b1;
                            end
                        end
                        ST_WDATA: begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (byte_end) begin
                                first_done <= 1'b1;
                                if (mode != BM_SINGLE || !first_done) begin
                                    wr_pend <= 1'b1;
                                    wbyte_q <= in_byte;
                                end
                            end
                        end
                        ST_REGOUT: begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (byte_end) rd_buf <= reg_is_size ? size_reg : status;
                        end
                        default: bit_cnt <= bit_cnt + 1'b1;
                    endcase
                end
                if (fall && (state == ST_RDATA || state == ST_REGOUT)) begin
                    if (bit_cnt == '0) begin
                        if (state == ST_RDATA && mode == BM_SINGLE && first_done) begin
                            oe_q <= 1'b0;
                        end else begin
                            so_q  <= rd_buf[7];
                            tx_sh <= {rd_buf[6:0], 1'b0};
                            oe_q  <= 1'b1;
                        end
                    end else begin
                        so_q  <= tx_sh[7];
                        tx_sh <= {tx_sh[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign so        = so_q;
    assign so_oe     = oe_q & ~paused & ~cs_n;
    assign mem_re    = fetch_pend;
    assign mem_we    = wr_pend;
    assign mem_wdata = wbyte_q;

    p_cs_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (state == ST_IDLE && !oe_q));

    p_pause_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
        paused |=> (cs_n || $stable(bit_cnt)));

    p_so_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(so_q));

    p_discard_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISCARD) |-> !oe_q);

    p_one_access_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));
endmodule

// File: tb/test_spi_sram_front.sv
module test_spi_sram_front;
    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_pause = 1'b0;
    logic so, so_oe, mem_re, mem_we;
    logic [15:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = 8'h00;

    int total = 0, bad = 0, we_cnt = 0;
    bit done = 0, idle_hi = 0;
    logic [1:0] cur_mode = 2'b00;
    logic held_oe;
    logic [7:0] arr [logic [15:0]];
    logic [7:0] refm [logic [15:0]];

    always #2 clk = ~clk;

    spi_sram_front i_spi_sram_front (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_pause(hold_pause),
        .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] dflt(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] arr_rd(input logic [15:0] a);
        return arr.exists(a) ? arr[a] : dflt(a);
    endfunction

    function automatic logic [7:0] ref_rd(input logic [15:0] a);
        return refm.exists(a) ? refm[a] : dflt(a);
    endfunction

    function automatic logic [15:0] first_a(input logic [15:0] a, input logic [1:0] m);
        return (m == 2'b10) ? {a[15:5], 5'b0} : a;
    endfunction

    function automatic logic [15:0] next_a(input logic [15:0] a, input logic [1:0] m, input logic [15:0] s);
        case (m)
            2'b01:   return {a[15:5], a[4:0] + 5'd1};
            2'b10:   return a + 16'd1;
            2'b11:   return (a == 16'hFFFF) ? s : a + 16'd1;
            default: return a;
        endcase
    endfunction

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= arr_rd(mem_addr);
        if (mem_we) begin
            arr[mem_addr] = mem_wdata;
            we_cnt++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic half();
        repeat (3) @(negedge clk);
    endtask

    task automatic cs_lo();
        @(negedge clk) sck = idle_hi;
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_hi();
        half();
        @(negedge clk) sck = idle_hi;
        half();
        @(negedge clk) cs_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R11", so_oe, 1'b0, "output enable after chip select high");
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic all_oe,
                         output logic none_oe, input int hold_bit);
        all_oe = 1'b1; none_oe = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) begin sck = 1'b0; si = tx[i]; end
            repeat (4) @(negedge clk);
            if (i == hold_bit) begin
                hold_pause = 1'b1;
                repeat (2) @(negedge clk);
                held_oe = so_oe;
                for (int k = 0; k < 3; k++) begin
                    sck = 1'b1; repeat (2) @(negedge clk); held_oe |= so_oe;
                    sck = 1'b0; repeat (2) @(negedge clk); held_oe |= so_oe;
                end
                hold_pause = 1'b0;
                repeat (2) @(negedge clk);
            end
            rx[i] = so;
            all_oe &= so_oe;
            none_oe &= ~so_oe;
            sck = 1'b1;
            half();
        end
    endtask

    task automatic do_read(input logic [15:0] addr, input int n, input int hold_byte, input int hold_bit);
        logic [7:0] rx; logic ao, no; logic [15:0] a;
        cs_lo();
        xbyte(8'h03, rx, ao, no, -1);
        check("R11", no, 1'b1, "no drive in command phase");
        xbyte(addr[15:8], rx, ao, no, -1);
        xbyte(addr[7:0], rx, ao, no, -1);
        check("R11", no, 1'b1, "no drive in address phase");
        a = first_a(addr, cur_mode);
        for (int k = 0; k < n; k++) begin
            xbyte(8'h00, rx, ao, no, (k == hold_byte) ? hold_bit : -1);
            if (cur_mode == 2'b00 && k > 0) begin
                check("R4", no, 1'b1, "single mode later byte undriven");
            end else begin
                check(cur_mode == 2'b00 ? "R2" : (cur_mode == 2'b01 ? "R5" : (cur_mode == 2'b10 ? "R6" : "R7")),
                      {a, rx}, {a, ref_rd(a)}, "read data {addr,byte}");
                check("R2", ao, 1'b1, "output enabled during read data");
                a = next_a(a, cur_mode, addr);
            end
            if (k == hold_byte) check("R12", held_oe, 1'b0, "output off while paused");
        end
        cs_hi();
    endtask

    task automatic do_write(input logic [15:0] addr, input int n);
        logic [7:0] rx, d; logic ao, no; logic [15:0] a;
        cs_lo();
        xbyte(8'h02, rx, ao, no, -1);
        xbyte(addr[15:8], rx, ao, no, -1);
        xbyte(addr[7:0], rx, ao, no, -1);
        a = first_a(addr, cur_mode);
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            xbyte(d, rx, ao, no, -1);
            check("R3", no, 1'b1, "no drive during write");
            if (!(cur_mode == 2'b00 && k > 0)) begin
                refm[a] = d;
                a = next_a(a, cur_mode, addr);
            end
        end
        cs_hi();
    endtask

    task automatic set_status(input logic [7:0] b, input bit extra, input logic [7:0] eb);
        logic [7:0] rx; logic ao, no;
        cs_lo();
        xbyte(8'h01, rx, ao, no, -1);
        xbyte(b, rx, ao, no, -1);
        if (extra) xbyte(eb, rx, ao, no, -1);
        cs_hi();
        cur_mode = b[7:6];
    endtask

    task automatic read_reg(input logic [7:0] cmd, input int n, input logic [7:0] exp, input string req);
        logic [7:0] rx; logic ao, no;
        cs_lo();
        xbyte(cmd, rx, ao, no, -1);
        for (int k = 0; k < n; k++) begin
            xbyte(8'h00, rx, ao, no, -1);
            check(req, rx, exp, "register byte");
            check(req, ao, 1'b1, "register output enabled");
        end
        cs_hi();
    endtask

    initial begin : watchdog
        repeat (180000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rx; logic ao, no;
        int wc;
        void'($urandom(32'd20231));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R11", so_oe, 1'b0, "reset output enable");
        read_reg(8'h05, 1, 8'h00, "R8");
        read_reg(8'h0E, 2, 8'h03, "R10");

        // single-byte mode: write two bytes, only first lands
        do_write(16'h1234, 2);
        do_read(16'h1234, 2, -1, -1);
        do_read(16'h1235, 1, -1, -1);   // R4: second write byte ignored

        // status register contents
        set_status(8'hFF, 1'b0, 8'h00);
        read_reg(8'h05, 1, 8'hC1, "R8");
        set_status(8'h40, 1'b1, 8'h80);
        read_reg(8'h05, 3, 8'h40, "R9");

        // page mode wrap
        do_write(16'h2A1E, 3);
        do_read(16'h2A1E, 3, -1, -1);
        do_read(16'h2A05, 34, 1, 4);

        // linear from page start, top-of-array wrap
        set_status(8'h80, 1'b0, 8'h00);
        do_write(16'hFFF9, 10);
        do_read(16'hFFE7, 34, -1, -1);

        // window mode wrap to start
        set_status(8'hC0, 1'b0, 8'h00);
        do_write(16'hFFFD, 5);
        do_read(16'hFFFD, 7, -1, -1);

        // mode 3 clock idle level
        idle_hi = 1;
        do_read(16'hFFFE, 4, -1, -1);
        read_reg(8'h0E, 1, 8'h03, "R10");
        idle_hi = 0;

        // unknown command
        wc = we_cnt;
        cs_lo();
        xbyte(8'hA2, rx, ao, no, -1);
        for (int k = 0; k < 4; k++) begin
            xbyte(8'($urandom), rx, ao, no, -1);
            check("R1", no, 1'b1, "unknown command leaves output off");
        end
        cs_hi();
        check("R1", we_cnt, wc, "no array write after unknown command");

        // abort in address phase, next command decoded fresh
        cs_lo();
        xbyte(8'h03, rx, ao, no, -1);
        xbyte(8'h77, rx, ao, no, -1);
        cs_hi();
        read_reg(8'h05, 1, 8'hC0, "R11");

        // hold disabled: pause request ignored
        set_status(8'h41, 1'b0, 8'h00);
        hold_pause = 1'b1;
        do_read(16'h2A1F, 3, -1, -1);
        hold_pause = 1'b0;

        // random bursts
        for (int it = 0; it < 10; it++) begin
            logic [1:0] m; logic [15:0] ad; int n;
            m = 2'($urandom);
            set_status({m, 6'b0}, 1'b0, 8'h00);
            ad = 16'($urandom);
            if ($urandom % 2 == 0) ad = 16'hFFFF - 16'($urandom % 4);
            n = 1 + int'($urandom % 6);
            do_write(ad, n);
            do_read(ad, n, -1, -1);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule